// File: doc/BRIEF.md
# Network wake-up frame filter

This block watches the bytes of received frames and decides whether a frame should wake a sleeping network controller. It holds four independent pattern filters. Each filter picks bytes out of a 31-byte window that starts at a programmable byte offset. A mask chooses which bytes in the window count. The chosen bytes run through a CRC-16 engine, and the signature left at the end of the frame is compared with a stored value. Filters are programmed through a simple write port, one field per write.

A frame counts as a wake-up frame when at least one filter is enabled and its signature matches. That filter's unicast/multicast selection must also agree with the frame. The destination address check must also have passed, unless global unicast mode is on. The outcome appears as a one-cycle vector of per-filter hits and a sticky wake flag. The wake flag drives an interrupt request through an enable input. The MAC receive path, which supplies the byte stream and the destination check result, is outside this block.

Top module: `wake_frame_filter`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into filter `cfg_sel`, into the field named by `cfg_field`: 0 = command (`cfg_data[3:0]`), 1 = offset (`cfg_data[7:0]`), 2 = byte mask, 3 = expected CRC (`cfg_data[15:0]`). The write takes effect after its clock edge, so a frame whose last byte arrives in the same cycle is judged with the earlier values. All fields reset to zero.
- R2: Byte positions count from 0 at the byte flagged `rx_sof`. A filter's signature is the CRC-16 with polynomial x^16+x^15+x^2+1 and initial value FFFFh. Bytes are fed least significant bit first, with no final inversion, in arrival order. It covers every byte at position offset+j for which mask bit j (0..30) is set. The filter matches only if this signature equals its expected CRC.
- R3: Command bit 0 enables the filter: a filter with bit 0 = 0 never reports a hit.
- R4: Command bit 3 selects the frame class: 0 accepts only unicast frames, 1 only multicast frames. A frame is multicast when bit 0 of its byte 0 is 1.
- R5: A filter whose offset is below 13 never reports a hit.
- R6: A filter does not match if the frame ends (`rx_eof`) before the last byte selected by its mask has arrived.
- R7: When `global_unicast` is 0, a hit also needs `rx_da_pass` high with the last byte. When `global_unicast` is 1, `rx_da_pass` is ignored.
- R8: In the cycle after the last byte of a frame, `hit_vec[k]` is 1 for exactly one cycle for each filter k that matched. Several bits may be set together, and the vector is 0 at all other times.
- R9: `wake_flag` is set by any hit and stays set until `wake_clr` is high at a clock edge. If a clear and a new hit fall in the same cycle, the flag stays set.
- R10: `irq` is `wake_flag` gated by `irq_en`.
- R11: Mask bit 31 is ignored: writing it as 1 gives the same result as writing it as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Filter index for the write |
| cfg_field | input | 2 | Field select: 0 command, 1 offset, 2 mask, 3 CRC |
| cfg_data | input | 32 | Write data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame (with `rx_valid`) |
| rx_eof | input | 1 | Byte is the last of a frame (with `rx_valid`) |
| rx_da_pass | input | 1 | Destination address filter passed, sampled with the last byte |
| global_unicast | input | 1 | 1 = hit does not require the destination check |
| irq_en | input | 1 | Interrupt enable for the wake flag |
| wake_clr | input | 1 | Clears the wake flag |
| hit_vec | output | 4 | Per-filter hit pulse, one cycle after the last byte |
| wake_flag | output | 1 | Sticky wake-up frame received status |
| irq | output | 1 | Interrupt request |

## Verification
The wake flag has a set path and a clear path, and both can act on the same edge. The bench raises `wake_clr` in the same cycle as the last byte of a matching frame. It expects the flag still to be set afterwards, and expects a plain clear on a later cycle to drop it. A configuration write can also coincide with the last byte of a frame. The bench rewrites a filter's expected CRC to a wrong value in that cycle. It expects that frame to hit with the old value and an identical later frame to miss.

// File: rtl/wff_pkg.sv
package wff_pkg;

   typedef enum logic [1:0] {
      FLD_CMD  = 2'd0,
      FLD_OFS  = 2'd1,
      FLD_MASK = 2'd2,
      FLD_CRC  = 2'd3
   } wff_field_e;

   localparam int unsigned CMD_W      = 4;
   localparam int unsigned CMD_EN_BIT = 0;
   localparam int unsigned CMD_MC_BIT = 3;

endpackage

// File: rtl/wff_crc_step.sv
module wff_crc_step #(
   parameter int unsigned          CRC_W     = 16,
   parameter int unsigned          DATA_W    = 8,
   parameter logic [CRC_W-1:0]     CRC_POLY  = 16'h8005,
   parameter bit                   LSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] dat,
   output logic [CRC_W-1:0]  crc_out
);

   function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
      logic [CRC_W-1:0] r;
      for (int i = 0; i < int'(CRC_W); i++) r[i] = v[CRC_W-1-i];
      return r;
   endfunction

   localparam logic [CRC_W-1:0] POLY_R = bit_rev(CRC_POLY);

   generate
      if (LSB_FIRST) begin : g_refl
         always_comb begin
            logic [CRC_W-1:0] c;
            logic             fb;
            c = crc_in;
            for (int b = 0; b < int'(DATA_W); b++) begin
               fb = c[0] ^ dat[b];
               c  = c >> 1;
               if (fb) c = c ^ POLY_R;
            end
            crc_out = c;
         end
      end else begin : g_norm
         always_comb begin
            logic [CRC_W-1:0] c;
            logic             fb;
            c = crc_in;
            for (int b = DATA_W - 1; b >= 0; b--) begin
               fb = c[CRC_W-1] ^ dat[b];
               c  = c << 1;
               if (fb) c = c ^ CRC_POLY;
            end
            crc_out = c;
         end
      end
   endgenerate

endmodule

// File: rtl/wff_track.sv
module wff_track #(
   parameter int unsigned POS_W  = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic              byte_sof,
   input  logic [DATA_W-1:0] byte_dat,
   output logic [POS_W-1:0]  cur_pos,
   output logic              frame_mc
);

   localparam logic [POS_W-1:0] POS_MAX = '1;

   logic [POS_W-1:0] pos_q;
   logic             mc_q;
   logic             sof_stb;

   assign sof_stb  = byte_vld && byte_sof;
   assign cur_pos  = sof_stb ? '0 : pos_q;
   assign frame_mc = sof_stb ? byte_dat[0] : mc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         mc_q  <= 1'b0;
      end else if (byte_vld) begin
         if (byte_sof) begin
            pos_q <= POS_W'(1);
            mc_q  <= byte_dat[0];
         end else if (pos_q != POS_MAX) begin
            pos_q <= pos_q + POS_W'(1);
         end
      end
   end

endmodule

// File: rtl/wff_lane.sv
module wff_lane
   import wff_pkg::*;
#(
   parameter int unsigned      IDX       = 0,
   parameter int unsigned      SEL_W     = 2,
   parameter int unsigned      CFG_W     = 32,
   parameter int unsigned      OFS_W     = 8,
   parameter int unsigned      MASK_W    = 31,
   parameter int unsigned      CRC_W     = 16,
   parameter int unsigned      POS_W     = 11,
   parameter int unsigned      MIN_OFS   = 13,
   parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8005,
   parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [1:0]        cfg_field,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic              byte_vld,
   input  logic              byte_sof,
   input  logic              byte_eof,
   input  logic [7:0]        byte_dat,
   input  logic [POS_W-1:0]  cur_pos,
   input  logic              frame_mc,
   input  logic              da_ok,
   output logic              match_now,
   output logic              hit_q
);

   localparam int unsigned RIDX_W = $clog2(MASK_W + 1);
   localparam int unsigned MEXT_W = 1 << RIDX_W;
   localparam int unsigned X_W    = POS_W + 1;

   logic [CMD_W-1:0]  cmd_q;
   logic [OFS_W-1:0]  ofs_q;
   logic [MASK_W-1:0] mask_q;
   logic [CRC_W-1:0]  ref_q;
   logic [CRC_W-1:0]  crc_q;
   logic [CRC_W-1:0]  crc_nx;
   logic [CRC_W-1:0]  crc_fin;
   logic              sel_me;

   assign sel_me = cfg_we && (cfg_sel == SEL_W'(IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         ofs_q  <= '0;
         mask_q <= '0;
         ref_q  <= '0;
      end else if (sel_me) begin
         case (wff_field_e'(cfg_field))
            FLD_CMD:  cmd_q  <= cfg_data[CMD_W-1:0];
            FLD_OFS:  ofs_q  <= cfg_data[OFS_W-1:0];
            FLD_MASK: mask_q <= cfg_data[MASK_W-1:0];
            default:  ref_q  <= cfg_data[CRC_W-1:0];
         endcase
      end
   end

   logic [X_W-1:0]    pos_x;
   logic [X_W-1:0]    ofs_x;
   logic [X_W-1:0]    rel;
   logic [MEXT_W-1:0] mask_ext;
   logic              in_win;
   logic              take;

   assign pos_x    = {1'b0, cur_pos};
   assign ofs_x    = X_W'(ofs_q);
   assign rel      = pos_x - ofs_x;
   assign mask_ext = MEXT_W'(mask_q);
   assign in_win   = (pos_x >= ofs_x) && (rel < X_W'(MASK_W)) &&
                     mask_ext[rel[RIDX_W-1:0]];
   assign take     = byte_vld && in_win;

   wff_crc_step #(
      .CRC_W     (CRC_W),
      .DATA_W    (8),
      .CRC_POLY  (CRC_POLY),
      .LSB_FIRST (LSB_FIRST)
   ) i_step (
      .crc_in  (crc_q),
      .dat     (byte_dat),
      .crc_out (crc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    crc_q <= CRC_INIT;
      else if (byte_vld && byte_sof) crc_q <= CRC_INIT;
      else if (take)                 crc_q <= crc_nx;
   end

   assign crc_fin = take ? crc_nx : crc_q;

   logic [RIDX_W-1:0] last_j;
   logic              any_m;
   logic [X_W-1:0]    need_pos;
   logic              complete;

   always_comb begin
      last_j = '0;
      any_m  = 1'b0;
      for (int j = 0; j < int'(MASK_W); j++) begin
         if (mask_q[j]) begin
            last_j = RIDX_W'(j);
            any_m  = 1'b1;
         end
      end
   end

   assign need_pos = ofs_x + X_W'(last_j);
   assign complete = !any_m || (pos_x >= need_pos);

   assign match_now = cmd_q[CMD_EN_BIT] &&
                      (ofs_q >= OFS_W'(MIN_OFS)) &&
                      (cmd_q[CMD_MC_BIT] == frame_mc) &&
                      complete &&
                      (crc_fin == ref_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= byte_vld && byte_eof && match_now && da_ok;
   end

   // R3
   hit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(cmd_q[CMD_EN_BIT]));

   // R5
   hit_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> ($past(ofs_q) >= OFS_W'(MIN_OFS)));

   // R7
   hit_da_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(da_ok));

   // R2
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_vld) |-> $stable(crc_q));

endmodule

// File: rtl/wake_frame_filter.sv
module wake_frame_filter #(
   parameter int unsigned          N_FILT    = 4,
   parameter int unsigned          SEL_W     = 2,
   parameter int unsigned          CFG_W     = 32,
   parameter int unsigned          OFS_W     = 8,
   parameter int unsigned          MASK_W    = 31,
   parameter int unsigned          CRC_W     = 16,
   parameter int unsigned          POS_W     = 11,
   parameter int unsigned          MIN_OFS   = 13,
   parameter logic [CRC_W-1:0]     CRC_POLY  = 16'h8005,
   parameter logic [CRC_W-1:0]     CRC_INIT  = 16'hFFFF,
   parameter bit                   LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [1:0]        cfg_field,
   input  logic [CFG_W-1:0]  cfg_data,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_da_pass,
   input  logic              global_unicast,
   input  logic              irq_en,
   input  logic              wake_clr,
   output logic [N_FILT-1:0] hit_vec,
   output logic              wake_flag,
   output logic              irq
);

   generate
      if (MASK_W > CFG_W - 1) begin : g_bad_mask
         $error("MASK_W must leave the top write data bit unused");
      end
      if (CRC_W > CFG_W || OFS_W > CFG_W) begin : g_bad_cfg
         $error("CRC_W and OFS_W must fit in CFG_W");
      end
      if (POS_W <= OFS_W) begin : g_bad_pos
         $error("POS_W must exceed OFS_W");
      end
      if ((1 << SEL_W) < N_FILT) begin : g_bad_sel
         $error("SEL_W too narrow for N_FILT");
      end
   endgenerate

   logic [POS_W-1:0]  cur_pos;
   logic              frame_mc;
   logic              da_ok;
   logic              eof_stb;
   logic [N_FILT-1:0] match_vec;

   assign da_ok   = global_unicast || rx_da_pass;
   assign eof_stb = rx_valid && rx_eof;

   wff_track #(
      .POS_W  (POS_W),
      .DATA_W (8)
   ) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (rx_valid),
      .byte_sof (rx_sof),
      .byte_dat (rx_data),
      .cur_pos  (cur_pos),
      .frame_mc (frame_mc)
   );

   generate
      for (genvar k = 0; k < int'(N_FILT); k++) begin : g_lane
         wff_lane #(
            .IDX       (k),
            .SEL_W     (SEL_W),
            .CFG_W     (CFG_W),
            .OFS_W     (OFS_W),
            .MASK_W    (MASK_W),
            .CRC_W     (CRC_W),
            .POS_W     (POS_W),
            .MIN_OFS   (MIN_OFS),
            .CRC_POLY  (CRC_POLY),
            .CRC_INIT  (CRC_INIT),
            .LSB_FIRST (LSB_FIRST)
         ) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we),
            .cfg_sel   (cfg_sel),
            .cfg_field (cfg_field),
            .cfg_data  (cfg_data),
            .byte_vld  (rx_valid),
            .byte_sof  (rx_sof),
            .byte_eof  (rx_eof),
            .byte_dat  (rx_data),
            .cur_pos   (cur_pos),
            .frame_mc  (frame_mc),
            .da_ok     (da_ok),
            .match_now (match_vec[k]),
            .hit_q     (hit_vec[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wake_flag <= 1'b0;
      else if (eof_stb && da_ok && |match_vec) wake_flag <= 1'b1;
      else if (wake_clr)                       wake_flag <= 1'b0;
   end

   assign irq = wake_flag && irq_en;

   // R8
   hit_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |-> $past(rx_valid && rx_eof));

   // R9
   hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |-> wake_flag);

   // R9
   flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wake_flag) |-> $past(wake_clr));

endmodule

// File: tb/test_wake_frame_filter.sv
module test_wake_frame_filter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [1:0]  cfg_field;
   logic [31:0] cfg_data;
   logic        rx_valid;
   logic [7:0]  rx_data;
   logic        rx_sof;
   logic        rx_eof;
   logic        rx_da_pass;
   logic        global_unicast;
   logic        irq_en;
   logic        wake_clr;
   logic [3:0]  hit_vec;
   logic        wake_flag;
   logic        irq;

   always #4 clk = ~clk;

   wake_frame_filter i_wake_frame_filter (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_sel        (cfg_sel),
      .cfg_field      (cfg_field),
      .cfg_data       (cfg_data),
      .rx_valid       (rx_valid),
      .rx_data        (rx_data),
      .rx_sof         (rx_sof),
      .rx_eof         (rx_eof),
      .rx_da_pass     (rx_da_pass),
      .global_unicast (global_unicast),
      .irq_en         (irq_en),
      .wake_clr       (wake_clr),
      .hit_vec        (hit_vec),
      .wake_flag      (wake_flag),
      .irq            (irq)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [3:0]  sh_cmd [4];
   logic [7:0]  sh_ofs [4];
   logic [31:0] sh_msk [4];
   logic [15:0] sh_crc [4];
   logic [7:0]  frm [0:127];
   int          flen;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic shadow(input int k, input int f, input logic [31:0] v);
      case (f)
         0: sh_cmd[k] = v[3:0];
         1: sh_ofs[k] = v[7:0];
         2: sh_msk[k] = v;
         default: sh_crc[k] = v[15:0];
      endcase
   endtask

   task automatic wr(input int k, input int f, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(k); cfg_field = 2'(f); cfg_data = v;
      @(negedge clk);
      cfg_we = 1'b0;
      shadow(k, f, v);
   endtask

   task automatic disable_all();
      for (int k = 0; k < 4; k++) wr(k, 0, 32'h0);
   endtask

   task automatic clear_flag();
      @(negedge clk); wake_clr = 1'b1;
      @(negedge clk); wake_clr = 1'b0;
   endtask

   task automatic mk(input int seed, input bit mc, input int len);
      flen = len;
      for (int i = 0; i < len; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) & 255);
      frm[0][0] = mc;
   endtask

   // reference signature: MSB-first register on the same bit order, reversed at the end
   function automatic logic [15:0] crc_of(input int k);
      logic [15:0] c = 16'hFFFF;
      logic [15:0] r;
      logic        fb;
      for (int j = 0; j < 31; j++) begin
         if (sh_msk[k][j] && (int'(sh_ofs[k]) + j) < flen) begin
            for (int b = 0; b < 8; b++) begin
               fb = c[15] ^ frm[int'(sh_ofs[k]) + j][b];
               c  = {c[14:0], 1'b0};
               if (fb) c = c ^ 16'h8005;
            end
         end
      end
      for (int i = 0; i < 16; i++) r[i] = c[15 - i];
      return r;
   endfunction

   function automatic logic [3:0] model(input bit da);
      logic [3:0] e = '0;
      bit ok;
      for (int k = 0; k < 4; k++) begin
         ok = sh_cmd[k][0] && (sh_ofs[k] >= 8'd13) && (sh_cmd[k][3] == frm[0][0]);
         for (int j = 0; j < 31; j++)
            if (sh_msk[k][j] && (int'(sh_ofs[k]) + j) >= flen) ok = 1'b0;
         if (ok && crc_of(k) != sh_crc[k]) ok = 1'b0;
         e[k] = ok && (global_unicast || da);
      end
      return e;
   endfunction

   task automatic send(input bit da, input bit clr_end, input bit wr_end,
                       input int wk, input logic [31:0] wv);
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = frm[i];
         rx_sof = (i == 0); rx_eof = (i == flen - 1); rx_da_pass = da;
         if (i == flen - 1) begin
            wake_clr = clr_end;
            if (wr_end) begin
               cfg_we = 1'b1; cfg_sel = 2'(wk); cfg_field = 2'd3; cfg_data = wv;
            end
         end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; wake_clr = 1'b0; cfg_we = 1'b0;
      if (wr_end) shadow(wk, 3, wv);
   endtask

   task automatic run(input string tag, input bit da, input logic [3:0] exp_hits);
      logic [3:0] e;
      clear_flag();
      e = model(da);
      chk({tag, " model"}, 32'(e), 32'(exp_hits));
      send(da, 1'b0, 1'b0, 0, 0);
      chk({tag, " R8 hit_vec"}, 32'(hit_vec), 32'(e));
      chk({tag, " R9 wake_flag"}, 32'(wake_flag), 32'(|e));
      @(negedge clk);
      chk({tag, " R8 pulse width"}, 32'(hit_vec), 32'h0);
   endtask

   task automatic setup(input int k, input int ofs, input logic [31:0] msk, input logic [3:0] cmd);
      wr(k, 1, 32'(ofs));
      wr(k, 2, msk);
      wr(k, 3, 32'(crc_of(k)));
      wr(k, 0, 32'(cmd));
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] masks [4];
      masks[0] = 32'h0000_0001; masks[1] = 32'hFFFF_FFFF;
      masks[2] = 32'h5555_5555; masks[3] = 32'h4000_0001;
      for (int k = 0; k < 4; k++) begin
         sh_cmd[k] = '0; sh_ofs[k] = '0; sh_msk[k] = '0; sh_crc[k] = '0;
      end
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_field = '0; cfg_data = '0;
      rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0; rx_eof = 1'b0; rx_da_pass = 1'b0;
      global_unicast = 1'b0; irq_en = 1'b0; wake_clr = 1'b0;
      repeat (3) @(negedge clk);
      chk("reset R8 hit_vec", 32'(hit_vec), 32'h0);
      chk("reset R9 wake_flag", 32'(wake_flag), 32'h0);
      chk("reset R10 irq", 32'(irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all fields reset to zero, so no filter is enabled
      mk(1, 1'b0, 40);
      run("R1 reset config", 1'b1, 4'h0);

      // R2 R11 sweep over filters, offsets and masks
      for (int k = 0; k < 4; k++) begin
         for (int p = 0; p < 4; p++) begin
            disable_all();
            mk(k * 4 + p, 1'b0, 64);
            setup(k, 13 + p * 5 + k, masks[p], 4'h1);
            run(p == 1 ? "R11 mask31" : "R2 sweep", 1'b1, 4'(1 << k));
            wr(k, 3, 32'(sh_crc[k] ^ 16'h0001));
            run("R2 wrong crc", 1'b1, 4'h0);
         end
      end

      // R3 disabled filter with correct signature
      disable_all();
      mk(30, 1'b0, 50);
      setup(2, 20, 32'h0000_F00F, 4'h0);
      run("R3 disabled", 1'b1, 4'h0);
      wr(2, 0, 32'h1);
      run("R3 enabled", 1'b1, 4'h4);

      // R4 class selection
      disable_all();
      mk(31, 1'b1, 50);
      setup(1, 14, 32'h0000_0FF0, 4'h1);
      run("R4 unicast filter multicast frame", 1'b1, 4'h0);
      wr(1, 0, 32'h9);
      run("R4 multicast filter multicast frame", 1'b1, 4'h2);
      mk(31, 1'b0, 50);
      wr(1, 3, 32'(crc_of(1)));
      run("R4 multicast filter unicast frame", 1'b1, 4'h0);

      // R5 offset boundary
      disable_all();
      mk(32, 1'b0, 50);
      setup(3, 12, 32'h0000_0003, 4'h1);
      run("R5 offset 12", 1'b1, 4'h0);
      setup(3, 13, 32'h0000_0003, 4'h1);
      run("R5 offset 13", 1'b1, 4'h8);

      // R6 truncated frames
      disable_all();
      mk(33, 1'b0, 20);
      wr(0, 1, 32'd20); wr(0, 2, 32'h1); wr(0, 3, 32'hFFFF); wr(0, 0, 32'h1);
      run("R6 ends before masked byte", 1'b1, 4'h0);
      mk(33, 1'b0, 21);
      wr(0, 3, 32'(crc_of(0)));
      run("R6 ends on masked byte", 1'b1, 4'h1);

      // R7 destination check
      global_unicast = 1'b0;
      run("R7 da fail", 1'b0, 4'h0);
      global_unicast = 1'b1;
      run("R7 global unicast", 1'b0, 4'h1);
      global_unicast = 1'b0;

      // R8 several filters at once
      disable_all();
      mk(34, 1'b0, 60);
      setup(0, 13, 32'h0000_00FF, 4'h1);
      setup(1, 25, 32'h1234_5678, 4'h1);
      setup(2, 16, 32'h7FFF_0000, 4'h1);
      setup(3, 18, 32'h0000_0011, 4'h9);
      run("R8 three hits", 1'b1, 4'h7);

      // R10 interrupt gating
      irq_en = 1'b0;
      chk("R10 irq masked", 32'(irq), 32'h0);
      irq_en = 1'b1;
      #1;
      chk("R10 irq raised", 32'(irq), 32'h1);

      // R9 set wins over a clear in the same cycle
      send(1'b1, 1'b1, 1'b0, 0, 0);
      chk("R9 clear vs set", 32'(wake_flag), 32'h1);
      clear_flag();
      chk("R9 plain clear", 32'(wake_flag), 32'h0);
      chk("R10 irq after clear", 32'(irq), 32'h0);

      // R1 config write coinciding with last byte
      send(1'b1, 1'b0, 1'b1, 0, 32'(sh_crc[0] ^ 16'h8000));
      chk("R1 write on last byte", 32'(hit_vec), 32'h7);
      clear_flag();
      send(1'b1, 1'b0, 1'b0, 0, 0);
      chk("R1 write applied", 32'(hit_vec), 32'h6);
      chk("R1 model", 32'(model(1'b1)), 32'h6);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule